// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Selectable Write and Allocation Policies

This block is a small direct-mapped data cache placed between a processor port that asks for one byte per request and a line-wide memory port. Each request address is taken as an unsigned number: its lowest bits pick a byte inside a line, the next bits pick one of the cache lines, and the remaining upper bits form the tag kept with that line. Every line carries a valid flag and a modified flag. Each accepted request is answered once, and the answer says whether it hit or missed.

Two static inputs choose how writes behave. The first picks between writing through to memory on every store and deferring memory updates until a modified line is replaced. The second picks between pulling a missed line into the cache before a store and sending a missed store to memory alone. A four-state controller handles misses. It goes through idle, an optional victim flush, a line fetch and a response cycle. Two free-running counters report how many requests hit and how many missed.

Line reads on the memory side use a request that is held until a one-cycle valid pulse comes back. Memory writes are posted: a single-cycle write strobe carrying a line-aligned address, a full line of data and a per-byte mask.

Top module: `dm_cache_ctrl`

## Requirements
- R1: With the default parameters, address bits [2:0] select the byte, bits [6:3] select one of 16 lines and bits [15:7] are the tag. A read returns the byte at the offset within the addressed line, and that byte matches the most recent store to the address or else the memory contents.
- R2: After reset every line is invalid. The first access to any address misses, including an address whose tag and index are zero. Both counters read 0, ready is high and no memory request is active.
- R3: A request that finds a valid line with a matching tag is answered in the cycle after acceptance with the hit flag set. Ready stays high. A read hit causes no memory traffic.
- R4: A miss that needs a line drives exactly one line read and holds it until the valid pulse arrives. The answer, with the hit flag clear, appears in the cycle after that pulse. Ready stays low from acceptance until the end of the answer cycle.
- R5: When memory updates are not deferred, every store produces exactly one memory write whose mask has a single set bit. The write pulse falls in the same cycle as the answer.
- R6: When memory updates are deferred, a store hit produces no memory write and marks the line modified. When stores allocate, every memory write in this mode is a full-line write with all mask bits set.
- R7: A miss that replaces a valid modified line first writes that whole line to its old address in a single write cycle, then issues the line read, so the answer comes one cycle later than for a clean miss.
- R8: When stores allocate, a store miss fetches the line, merges the byte into it and keeps the line. A later access to the same line hits.
- R9: When stores do not allocate, a store miss is answered in the cycle after acceptance with the hit flag clear. It produces one single-byte memory write and no line read, and leaves the cache unchanged, so the next access to that line still misses. Read misses still fetch their line.
- R10: Each accepted request raises exactly one of the two counters by one.
- R11: The memory read request and the memory write strobe are never high in the same cycle.
- R12: The cache holds 16 lines of 8 bytes (128 bytes): after one line at each index has been fetched, reading all of them again hits every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_write_back | input | 1 | 1: defer memory updates until eviction; 0: write through on every store |
| cfg_write_alloc | input | 1 | 1: a store miss fetches its line; 0: a store miss goes only to memory |
| cpu_req | input | 1 | Request present |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Request is accepted at a clock edge where both cpu_req and this are high |
| cpu_resp_valid | output | 1 | One-cycle answer strobe |
| cpu_resp_hit | output | 1 | Answer was a hit |
| cpu_rdata | output | 8 | Load byte (zero for stores) |
| mem_rd | output | 1 | Line read request, held until mem_rvalid |
| mem_wr | output | 1 | One-cycle posted write strobe |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wline | output | 8*LINE_BYTES | Write data for a whole line |
| mem_wmask | output | LINE_BYTES | Per-byte write enable |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rline | input | 8*LINE_BYTES | Read line data |
| hit_count | output | CNT_W | Number of hits since reset |
| miss_count | output | CNT_W | Number of misses since reset |

## Verification
A wrong tag, valid or modified flag inside the cache does not show up when it goes wrong. It shows up at the next access to that line index: as a wrong hit flag, a wrong answer latency or a stale load byte, and in deferred mode as a missing or extra full-line write at eviction. The bench keeps its own model of which line occupies each index, of the byte values the program should see and of the memory image each policy should leave. It compares the answer cycle, hit flag, load data, counters and memory traffic for every request, and checks the whole memory image at the end of each policy run. A lost flush is therefore caught at the first later miss to the same index or at the final memory comparison, whichever comes first.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_FILL      = 2'd2,
        ST_RESPOND   = 2'd3
    } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
`timescale 1ns/1ps
module dmc_addr_split #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 3,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off
);
    // byte offset is the lowest field, line index above it, tag on top
    assign off = addr[OFF_W-1:0];
    assign idx = addr[OFF_W +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/dmc_line_store.sv
`timescale 1ns/1ps
module dmc_line_store #(
    parameter int LINES  = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 9,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_dirty
);
    logic [LINES-1:0]  valid_d, valid_q;
    logic [LINES-1:0]  dirty_d, dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] data_q [LINES];

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_line  = data_q[idx];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (wr_en) begin
            valid_d[idx] = 1'b1;
            dirty_d[idx] = wr_dirty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= wr_tag;
            data_q[idx] <= wr_line;
        end
    end

    // R2
    modified_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/dmc_byte_lane.sv
`timescale 1ns/1ps
module dmc_byte_lane #(
    parameter int LINE_BYTES = 8,
    parameter int OFF_W      = 3
) (
    input  logic [8*LINE_BYTES-1:0] line_in,
    input  logic [OFF_W-1:0]        off,
    input  logic [7:0]              wbyte,
    output logic [8*LINE_BYTES-1:0] line_merged,
    output logic [LINE_BYTES-1:0]   lane_mask,
    output logic [7:0]              rbyte
);
    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
        assign lane_mask[g] = (off == OFF_W'(g));
        assign line_merged[8*g +: 8] = lane_mask[g] ? wbyte : line_in[8*g +: 8];
    end

    always_comb begin
        rbyte = '0;
        for (int i = 0; i < LINE_BYTES; i++) begin
            if (lane_mask[i]) rbyte = line_in[8*i +: 8];
        end
    end
endmodule

// File: rtl/dm_cache_ctrl.sv
`timescale 1ns/1ps
module dm_cache_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 8,
    parameter int LINES      = 16,
    parameter int CNT_W      = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_write_back,
    input  logic                           cfg_write_alloc,
    input  logic                           cpu_req,
    input  logic                           cpu_we,
    input  logic [ADDR_W-1:0]              cpu_addr,
    input  logic [BYTE_W-1:0]              cpu_wdata,
    output logic                           cpu_ready,
    output logic                           cpu_resp_valid,
    output logic                           cpu_resp_hit,
    output logic [BYTE_W-1:0]              cpu_rdata,
    output logic                           mem_rd,
    output logic                           mem_wr,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [BYTE_W*LINE_BYTES-1:0]   mem_wline,
    output logic [LINE_BYTES-1:0]          mem_wmask,
    input  logic                           mem_rvalid,
    input  logic [BYTE_W*LINE_BYTES-1:0]   mem_rline,
    output logic [CNT_W-1:0]               hit_count,
    output logic [CNT_W-1:0]               miss_count
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = BYTE_W * LINE_BYTES;

    typedef struct packed {
        dmc_state_e             st;
        logic [ADDR_W-1:0]      req_addr;
        logic                   req_we;
        logic [BYTE_W-1:0]      req_wdata;
        logic                   resp_valid;
        logic                   resp_hit;
        logic [BYTE_W-1:0]      rdata;
        logic                   mem_rd;
        logic                   mem_wr;
        logic [ADDR_W-1:0]      mem_addr;
        logic [LINE_W-1:0]      mem_wline;
        logic [LINE_BYTES-1:0]  mem_wmask;
        logic [CNT_W-1:0]       hits;
        logic [CNT_W-1:0]       misses;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    // lookup address: live request while idle, stored request otherwise
    logic [ADDR_W-1:0] look_addr;
    logic [TAG_W-1:0]  l_tag;
    logic [IDX_W-1:0]  l_idx;
    logic [OFF_W-1:0]  l_off;

    assign look_addr = (r_q.st == ST_IDLE) ? cpu_addr : r_q.req_addr;

    dmc_addr_split #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) i_split (
        .addr (look_addr),
        .tag  (l_tag),
        .idx  (l_idx),
        .off  (l_off)
    );

    logic              s_valid, s_dirty;
    logic [TAG_W-1:0]  s_tag;
    logic [LINE_W-1:0] s_line;
    logic              st_we, st_dirty;
    logic [LINE_W-1:0] st_line;

    dmc_line_store #(
        .LINES  (LINES),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (l_idx),
        .rd_valid (s_valid),
        .rd_dirty (s_dirty),
        .rd_tag   (s_tag),
        .rd_line  (s_line),
        .wr_en    (st_we),
        .wr_tag   (l_tag),
        .wr_line  (st_line),
        .wr_dirty (st_dirty)
    );

    // valid flag is checked before the tag compare
    logic look_hit;
    assign look_hit = s_valid && (s_tag == l_tag);

    logic [LINE_W-1:0]     lane_src, merged;
    logic [LINE_BYTES-1:0] lane_mask;
    logic [BYTE_W-1:0]     lane_wbyte, lane_rbyte;

    assign lane_src   = (r_q.st == ST_FILL) ? mem_rline : s_line;
    assign lane_wbyte = (r_q.st == ST_IDLE) ? cpu_wdata : r_q.req_wdata;

    dmc_byte_lane #(
        .LINE_BYTES (LINE_BYTES),
        .OFF_W      (OFF_W)
    ) i_lane (
        .line_in     (lane_src),
        .off         (l_off),
        .wbyte       (lane_wbyte),
        .line_merged (merged),
        .lane_mask   (lane_mask),
        .rbyte       (lane_rbyte)
    );

    logic [ADDR_W-1:0] fetch_addr, victim_addr;
    assign fetch_addr  = {l_tag, l_idx, {OFF_W{1'b0}}};
    assign victim_addr = {s_tag, l_idx, {OFF_W{1'b0}}};

    always_comb begin
        r_d            = r_q;
        r_d.resp_valid = 1'b0;
        r_d.mem_wr     = 1'b0;
        st_we          = 1'b0;
        st_dirty       = 1'b0;
        st_line        = merged;

        unique case (r_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    r_d.req_addr  = cpu_addr;
                    r_d.req_we    = cpu_we;
                    r_d.req_wdata = cpu_wdata;
                    if (look_hit) begin
                        r_d.hits       = r_q.hits + CNT_W'(1);
                        r_d.resp_valid = 1'b1;
                        r_d.resp_hit   = 1'b1;
                        r_d.rdata      = cpu_we ? '0 : lane_rbyte;
                        if (cpu_we) begin
                            st_we    = 1'b1;
                            st_dirty = cfg_write_back | s_dirty;
                            if (!cfg_write_back) begin
                                r_d.mem_wr    = 1'b1;
                                r_d.mem_addr  = fetch_addr;
                                r_d.mem_wline = merged;
                                r_d.mem_wmask = lane_mask;
                            end
                        end
                    end else begin
                        r_d.misses = r_q.misses + CNT_W'(1);
                        if (cpu_we && !cfg_write_alloc) begin
                            r_d.resp_valid = 1'b1;
                            r_d.resp_hit   = 1'b0;
                            r_d.rdata      = '0;
                            r_d.mem_wr     = 1'b1;
                            r_d.mem_addr   = fetch_addr;
                            r_d.mem_wline  = {LINE_BYTES{cpu_wdata}};
                            r_d.mem_wmask  = lane_mask;
                        end else if (s_valid && s_dirty) begin
                            r_d.st        = ST_WRITEBACK;
                            r_d.mem_wr    = 1'b1;
                            r_d.mem_addr  = victim_addr;
                            r_d.mem_wline = s_line;
                            r_d.mem_wmask = '1;
                        end else begin
                            r_d.st       = ST_FILL;
                            r_d.mem_rd   = 1'b1;
                            r_d.mem_addr = fetch_addr;
                        end
                    end
                end
            end
            ST_WRITEBACK: begin
                r_d.st       = ST_FILL;
                r_d.mem_rd   = 1'b1;
                r_d.mem_addr = fetch_addr;
            end
            ST_FILL: begin
                if (mem_rvalid) begin
                    r_d.mem_rd     = 1'b0;
                    st_we          = 1'b1;
                    st_line        = r_q.req_we ? merged : mem_rline;
                    st_dirty       = r_q.req_we && cfg_write_back;
                    r_d.resp_valid = 1'b1;
                    r_d.resp_hit   = 1'b0;
                    r_d.rdata      = r_q.req_we ? '0 : lane_rbyte;
                    r_d.st         = ST_RESPOND;
                    if (r_q.req_we && !cfg_write_back) begin
                        r_d.mem_wr    = 1'b1;
                        r_d.mem_addr  = fetch_addr;
                        r_d.mem_wline = merged;
                        r_d.mem_wmask = lane_mask;
                    end
                end
            end
            ST_RESPOND: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q            <= '0;
            r_q.st         <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_ready      = (r_q.st == ST_IDLE);
    assign cpu_resp_valid = r_q.resp_valid;
    assign cpu_resp_hit   = r_q.resp_hit;
    assign cpu_rdata      = r_q.rdata;
    assign mem_rd         = r_q.mem_rd;
    assign mem_wr         = r_q.mem_wr;
    assign mem_addr       = r_q.mem_addr;
    assign mem_wline      = r_q.mem_wline;
    assign mem_wmask      = r_q.mem_wmask;
    assign hit_count      = r_q.hits;
    assign miss_count     = r_q.misses;

    // R11
    one_mem_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rvalid) |=> mem_rd);

    // R4
    rd_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !cpu_ready);

    // R3
    hit_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && look_hit) |=> (cpu_resp_valid && cpu_resp_hit));

    // R5
    wt_single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_write_back && mem_wr) |-> ($countones(mem_wmask) == 1));

    // R6
    wb_full_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_write_back && cfg_write_alloc && mem_wr) |-> (&mem_wmask));

    // R7
    flush_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WRITEBACK) |=> (mem_rd && !mem_wr));

    // R10
    hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + CNT_W'(1)));

    // R10
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + CNT_W'(1)));
endmodule

// File: tb/test_dm_cache_ctrl.sv
`timescale 1ns/1ps
module test_dm_cache_ctrl;
    localparam int ADDR_W = 16;
    localparam int LB     = 8;
    localparam int NL     = 16;
    localparam int CNT_W  = 16;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_write_back = 1'b0;
    logic cfg_write_alloc = 1'b0;
    logic cpu_req = 1'b0;
    logic cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic cpu_ready, cpu_resp_valid, cpu_resp_hit;
    logic [7:0] cpu_rdata;
    logic mem_rd, mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [8*LB-1:0] mem_wline;
    logic [LB-1:0] mem_wmask;
    logic mem_rvalid = 1'b0;
    logic [8*LB-1:0] mem_rline = '0;
    logic [CNT_W-1:0] hit_count, miss_count;

    always #2.5 clk = ~clk;

    dm_cache_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .LINES(NL), .CNT_W(CNT_W)) i_dm_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_write_back(cfg_write_back), .cfg_write_alloc(cfg_write_alloc),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit),
        .cpu_rdata(cpu_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wline(mem_wline),
        .mem_wmask(mem_wmask), .mem_rvalid(mem_rvalid), .mem_rline(mem_rline),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // behavioural memory: posted writes, line reads after LAT cycles
    logic [7:0] memarr [int];
    int wr_seen = 0;
    int rd_seen = 0;
    int rd_wait = 0;

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37) + (a >> 5) * 11 + 5);
    endfunction

    function automatic logic [7:0] mem_get(input int a);
        return memarr.exists(a) ? memarr[a] : init_val(a);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rvalid = 1'b0;
            rd_wait = 0;
        end else begin
            if (mem_wr) begin
                for (int b = 0; b < LB; b++)
                    if (mem_wmask[b]) memarr[int'(mem_addr) + b] = mem_wline[8*b +: 8];
                wr_seen++;
            end
            if (mem_rd && !mem_rvalid) begin
                rd_wait++;
                if (rd_wait == LAT) begin
                    for (int b = 0; b < LB; b++)
                        mem_rline[8*b +: 8] = mem_get(int'(mem_addr) + b);
                    mem_rvalid = 1'b1;
                    rd_wait = 0;
                    rd_seen++;
                end
            end else begin
                mem_rvalid = 1'b0;
            end
        end
    end

    // reference model
    bit         m_valid [NL];
    bit         m_dirty [NL];
    int         m_tag   [NL];
    logic [7:0] prog    [int];
    logic [7:0] expm    [int];
    int         m_hits, m_misses;

    function automatic logic [7:0] prog_get(input int a);
        return prog.exists(a) ? prog[a] : init_val(a);
    endfunction

    function automatic logic [7:0] expm_get(input int a);
        return expm.exists(a) ? expm[a] : init_val(a);
    endfunction

    task automatic access(input bit we, input int addr, input logic [7:0] data);
        int idx = (addr >> 3) % NL;
        int tg = addr >> 7;
        int lbase = addr & ~(LB - 1);
        bit e_hit;
        int e_k, e_wr, e_rd;
        logic [7:0] e_data;
        string rq;
        int wr0, rd0, k;
        bit busy_ok;

        e_data = prog_get(addr);
        if (m_valid[idx] && m_tag[idx] == tg) begin
            e_hit = 1; e_k = 0; e_rd = 0; rq = "R3";
            e_wr = (we && !cfg_write_back) ? 1 : 0;
            m_hits++;
            if (we) begin
                prog[addr] = data;
                if (cfg_write_back) m_dirty[idx] = 1;
                else expm[addr] = data;
            end
        end else begin
            e_hit = 0;
            m_misses++;
            if (we && !cfg_write_alloc) begin
                e_k = 0; e_wr = 1; e_rd = 0; rq = "R9";
                prog[addr] = data;
                expm[addr] = data;
            end else begin
                e_rd = 1;
                e_wr = (we && !cfg_write_back) ? 1 : 0;
                if (m_valid[idx] && m_dirty[idx]) begin
                    int vb = m_tag[idx] * 128 + idx * LB;
                    e_k = LAT + 1; e_wr++; rq = "R7";
                    for (int b = 0; b < LB; b++) expm[vb + b] = prog_get(vb + b);
                end else begin
                    e_k = LAT; rq = we ? "R8" : "R4";
                end
                m_valid[idx] = 1; m_tag[idx] = tg;
                m_dirty[idx] = we && cfg_write_back;
                if (we) begin
                    prog[addr] = data;
                    if (!cfg_write_back) expm[addr] = data;
                end
            end
        end

        wr0 = wr_seen; rd0 = rd_seen;
        check(cpu_ready == 1'b1, "R4", "ready before request", cpu_ready, 1);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = data;
        @(posedge clk);
        @(negedge clk); #1;
        cpu_req = 1'b0;
        k = 0; busy_ok = 1;
        while (!cpu_resp_valid && k < 40) begin
            if (cpu_ready) busy_ok = 0;
            @(negedge clk); #1;
            k++;
        end
        check(k == e_k, rq, $sformatf("answer latency addr %0h", addr), k, e_k);
        check(busy_ok, "R4", "ready low while waiting", busy_ok, 1);
        check(cpu_resp_hit == e_hit, e_hit ? "R3" : "R2", $sformatf("hit flag addr %0h", addr),
              cpu_resp_hit, e_hit);
        if (!we)
            check(cpu_rdata == e_data, "R1", $sformatf("load byte addr %0h", addr), cpu_rdata, e_data);
        check(hit_count == CNT_W'(m_hits), "R10", "hit counter", hit_count, m_hits);
        check(miss_count == CNT_W'(m_misses), "R10", "miss counter", miss_count, m_misses);
        check(wr_seen - wr0 == e_wr, we ? (cfg_write_back ? "R6" : "R5") : "R7",
              $sformatf("memory writes addr %0h", addr), wr_seen - wr0, e_wr);
        check(rd_seen - rd0 == e_rd, (we && !cfg_write_alloc) ? "R9" : "R4",
              $sformatf("line reads addr %0h", addr), rd_seen - rd0, e_rd);
        if (e_k == 0) begin
            check(cpu_ready == 1'b1, "R3", "ready after quick answer", cpu_ready, 1);
        end else begin
            check(cpu_ready == 1'b0, "R4", "ready in answer cycle", cpu_ready, 0);
            @(negedge clk); #1;
            check(cpu_ready == 1'b1, "R4", "ready after answer", cpu_ready, 1);
        end
        if (lbase < 0) $display("unreachable");
    endtask

    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic run_phase(input bit wb, input bit alloc);
        rst_n = 1'b0;
        cfg_write_back = wb;
        cfg_write_alloc = alloc;
        memarr.delete(); prog.delete(); expm.delete();
        for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; end
        m_hits = 0; m_misses = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1;
        // R2: reset state
        check(cpu_ready == 1'b1, "R2", "ready after reset", cpu_ready, 1);
        check(cpu_resp_valid == 1'b0, "R2", "no answer after reset", cpu_resp_valid, 0);
        check(!mem_rd && !mem_wr, "R2", "memory idle after reset", {mem_rd, mem_wr}, 0);
        check(hit_count == 0 && miss_count == 0, "R2", "counters after reset",
              {hit_count, miss_count}, 0);
        @(negedge clk); #1;

        // directed pattern
        access(0, 16'h0000, 8'h00);   // R2: tag 0 index 0, invalid line misses
        access(0, 16'h0005, 8'h00);   // R1: other byte of same line hits
        access(1, 16'h0003, 8'hA5);   // R5/R6: store hit
        access(0, 16'h0003, 8'h00);   // R1: sees stored byte
        access(0, 16'h0080, 8'h00);   // R7: same index, new tag
        access(0, 16'h0003, 8'h00);   // refetch returns stored byte
        access(1, 16'h0108, 8'h3C);   // R8/R9: store miss
        access(0, 16'h010F, 8'h00);   // R8 hit or R9 miss
        access(0, 16'h0108, 8'h00);
        // R12: fill every index, then all hit
        for (int i = 0; i < NL; i++) access(0, 16'h0100 + i * LB, 8'h00);
        for (int i = 0; i < NL; i++) access(0, 16'h0100 + i * LB + (i % LB), 8'h00);
        for (int i = 0; i < NL; i++) access(1, 16'h0100 + i * LB + 1, 8'(i * 3 + 1));
        // mixed traffic over four tags
        for (int n = 0; n < 160; n++) begin
            lfsr = lfsr_next(lfsr);
            access(lfsr[12], int'(lfsr[8:0]), lfsr[15:8] ^ 8'h5A);
        end

        // R6/R7: memory image matches policy expectation
        begin
            int bad = -1;
            for (int a = 0; a < 512; a++)
                if (bad < 0 && mem_get(a) != expm_get(a)) bad = a;
            check(bad < 0, wb ? "R6" : "R5", $sformatf("memory image at %0h", bad),
                  bad < 0 ? 0 : mem_get(bad), bad < 0 ? 0 : expm_get(bad));
        end
    endtask

    initial begin
        run_phase(1'b1, 1'b1);
        run_phase(1'b0, 1'b1);
        run_phase(1'b0, 1'b0);
        run_phase(1'b1, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule